// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block is the strobe and flag logic of a two-way 8-bit parallel port that hangs off a small processor's bus. On the sending side a write to the port's data address captures the byte from the processor bus. An active-low ready strobe then tells the attached device that fresh data is waiting. The data pins drive by default, and the device can turn them off with an output-disable pin when it shares a bidirectional bus.

On the receiving side the device pulls a data-ready line low. The block samples that line on each phase-2 rising edge, which reaches it as a one-cycle pulse on `ph2_edge`. A rising edge of the sampled copy sets a busy flag. The flag drives an acknowledge line high, which tells the device that the host has not yet taken the byte. The processor sees the flag as one bit of an auxiliary status read, with the sense inverted: 0 means data is waiting and 1 means nothing is waiting. A read of the input data address empties the flag, and so does the power-on clear.

The sending side is a three-state machine. OUT_IDLE goes to OUT_ARMED on the leading edge of the write select, and the byte is captured on the same edge. OUT_ARMED goes to OUT_STROBE on the next phase-2 pulse. OUT_STROBE goes back to OUT_IDLE on a phase-2 pulse that falls inside the bus-cycle sync, which is the middle of that sync. A new write leading edge moves any state to OUT_ARMED. The receiving side has two states. IN_EMPTY goes to IN_FULL on a rising edge of the sampled strobe. IN_FULL goes to IN_EMPTY on a data-port read. A read also holds IN_EMPTY and wins over a set arriving in the same cycle.

Top module: `pp_handshake`

## Requirements
- R1: While `pwr_clr` is high and after it falls: `strobe_n` is 1, `ack` is 0, `pdata` is 0x00 and `aux_en` is 0x00.
- R2: `pdata` takes the value of `bus_din` on the clock in which `wr_sel` is high and was low the cycle before. Holding `wr_sel` high does not capture again, and `pdata` does not change while `wr_sel` is low.
- R3: `strobe_n` goes low one clock after the first `ph2_edge` pulse that comes after the capture clock. A `ph2_edge` in the capture cycle itself does not count.
- R4: A low `strobe_n` returns to 1 one clock after a cycle with both `ph2_edge` and `cyc_sync` high. `cyc_sync` without `ph2_edge` leaves it low.
- R5: A new write leading edge while the strobe is low releases the strobe on the next clock, captures the new byte and re-arms for the next `ph2_edge`.
- R6: `pdata_en` is the inverse of `out_dis`, with no clock delay.
- R7: `rdy_n` is looked at only in cycles where `ph2_edge` is high. A low sample taken there sets `ack` two clocks later.
- R8: `ack` is high exactly while the input flag is full.
- R9: While `stat_sel` is high, `aux_en` is 0x02 and `aux_val` bit 1 is 0 when the flag is full and 1 when it is empty. All other bits, and both buses while `stat_sel` is low, are 0.
- R10: `rd_sel` high empties the flag on the next clock. It wins over a set in the same cycle, and that set is not kept.
- R11: If `rdy_n` stays low across a read, the flag stays empty. It sets again only after `rdy_n` is sampled high and then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_clr | input | 1 | Asynchronous power-on/restart clear, active high |
| ph2_edge | input | 1 | One-cycle pulse marking a phase-2 rising edge |
| cyc_sync | input | 1 | Bus-cycle sync level |
| wr_sel | input | 1 | Output data port write select, active high |
| bus_din | input | 8 | Processor data bus during writes |
| out_dis | input | 1 | Device output-disable for the data pins, active high |
| pdata | output | 8 | Captured output byte |
| pdata_en | output | 1 | Drive enable for the output data pins |
| strobe_n | output | 1 | Output-ready strobe to the device, active low |
| rdy_n | input | 1 | Input data-ready strobe from the device, active low |
| rd_sel | input | 1 | Input data port read select, active high |
| ack | output | 1 | Busy/acknowledge to the device, high while data is unaccepted |
| stat_sel | input | 1 | Auxiliary status read select, active high |
| aux_en | output | 8 | Per-bit drive enable onto the internal data bus |
| aux_val | output | 8 | Per-bit value for the internal data bus |

## Verification
A stuck or skipped sending state shows on `strobe_n` within one clock of the phase-2 pulse that should have moved it. If it stays in OUT_ARMED, the strobe never falls. If it leaves OUT_STROBE early, the strobe rises without a sync. A wrong receiving state shows on `ack` and on status bit 1 in the same cycle, because both are taken straight from the flag. A sampler that misses the edge rule shows up as a second set after a read while the strobe is held low.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_ARMED  = 2'd1,
        OUT_STROBE = 2'd2
    } out_st_t;

    typedef enum logic {
        IN_EMPTY = 1'b0,
        IN_FULL  = 1'b1
    } in_st_t;

endpackage

// File: rtl/pp_out_fsm.sv
module pp_out_fsm
    import pp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          pwr_clr,
    input  logic          wr_sel,
    input  logic          ph2_edge,
    input  logic          cyc_sync,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] dq,
    output logic          strobe_n
);

    out_st_t st_q, st_d;
    logic    wr_sel_q;
    logic    wr_lead;

    // leading edge of the write select
    assign wr_lead = wr_sel && !wr_sel_q;

    always_ff @(posedge clk or posedge pwr_clr) begin
        if (pwr_clr) begin
            st_q     <= OUT_IDLE;
            wr_sel_q <= 1'b0;
            dq       <= '0;
        end else begin
            st_q     <= st_d;
            wr_sel_q <= wr_sel;
            if (wr_lead) begin
                dq <= bus_din;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_lead) begin
            st_d = OUT_ARMED;
        end else begin
            unique case (st_q)
                OUT_IDLE:   st_d = OUT_IDLE;
                OUT_ARMED:  if (ph2_edge) st_d = OUT_STROBE;
                OUT_STROBE: if (ph2_edge && cyc_sync) st_d = OUT_IDLE;
                default:    st_d = OUT_IDLE;
            endcase
        end
    end

    always_comb begin
        strobe_n = (st_q != OUT_STROBE);
    end

endmodule

// File: rtl/pp_strobe_sampler.sv
module pp_strobe_sampler (
    input  logic clk,
    input  logic pwr_clr,
    input  logic ph2_edge,
    input  logic rdy_n,
    output logic set_pulse
);

    logic smp_q;
    logic smp_d1;

    always_ff @(posedge clk or posedge pwr_clr) begin
        if (pwr_clr) begin
            smp_q  <= 1'b0;
            smp_d1 <= 1'b0;
        end else begin
            if (ph2_edge) begin
                smp_q <= !rdy_n;
            end
            smp_d1 <= smp_q;
        end
    end

    // only a fresh rise of the sampled strobe may set the flag
    assign set_pulse = smp_q && !smp_d1;

endmodule

// File: rtl/pp_in_fsm.sv
module pp_in_fsm
    import pp_pkg::*;
(
    input  logic clk,
    input  logic pwr_clr,
    input  logic set_pulse,
    input  logic rd_sel,
    output logic full
);

    in_st_t st_q, st_d;

    always_ff @(posedge clk or posedge pwr_clr) begin
        if (pwr_clr) begin
            st_q <= IN_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IN_EMPTY: if (!rd_sel && set_pulse) st_d = IN_FULL;
            IN_FULL:  if (rd_sel) st_d = IN_EMPTY;
        endcase
    end

    always_comb begin
        full = (st_q == IN_FULL);
    end

endmodule

// File: rtl/pp_handshake.sv
module pp_handshake #(
    parameter int DW       = 8,
    parameter int STAT_POS = 1
) (
    input  logic          clk,
    input  logic          pwr_clr,
    input  logic          ph2_edge,
    input  logic          cyc_sync,
    input  logic          wr_sel,
    input  logic [DW-1:0] bus_din,
    input  logic          out_dis,
    output logic [DW-1:0] pdata,
    output logic          pdata_en,
    output logic          strobe_n,
    input  logic          rdy_n,
    input  logic          rd_sel,
    output logic          ack,
    input  logic          stat_sel,
    output logic [DW-1:0] aux_en,
    output logic [DW-1:0] aux_val
);

    localparam int LAST = DW - 1;

    logic set_pulse;
    logic full;

    pp_out_fsm #(.DW(DW)) u_out (
        .clk      (clk),
        .pwr_clr  (pwr_clr),
        .wr_sel   (wr_sel),
        .ph2_edge (ph2_edge),
        .cyc_sync (cyc_sync),
        .bus_din  (bus_din),
        .dq       (pdata),
        .strobe_n (strobe_n)
    );

    pp_strobe_sampler u_smp (
        .clk       (clk),
        .pwr_clr   (pwr_clr),
        .ph2_edge  (ph2_edge),
        .rdy_n     (rdy_n),
        .set_pulse (set_pulse)
    );

    pp_in_fsm u_in (
        .clk       (clk),
        .pwr_clr   (pwr_clr),
        .set_pulse (set_pulse),
        .rd_sel    (rd_sel),
        .full      (full)
    );

    assign pdata_en = !out_dis;
    assign ack      = full;

    // status lane: only the chosen bit is driven, with inverted ready sense
    for (genvar i = 0; i <= LAST; i++) begin : g_aux
        if (i == STAT_POS) begin : g_on
            assign aux_en[i]  = stat_sel;
            assign aux_val[i] = stat_sel && !full;
        end else begin : g_off
            assign aux_en[i]  = 1'b0;
            assign aux_val[i] = 1'b0;
        end
    end

endmodule

// File: rtl/pp_handshake_chk.sv
module pp_handshake_chk #(
    parameter int DW       = 8,
    parameter int STAT_POS = 1
) (
    input logic          clk,
    input logic          pwr_clr,
    input logic          ph2_edge,
    input logic          cyc_sync,
    input logic          wr_sel,
    input logic          rdy_n,
    input logic          rd_sel,
    input logic          stat_sel,
    input logic [DW-1:0] pdata,
    input logic          strobe_n,
    input logic          ack,
    input logic [DW-1:0] aux_val
);

    // R2: the captured byte holds while no write select is present
    assert_pdata_hold_R2: assert property (@(posedge clk) disable iff (pwr_clr)
        !wr_sel |=> $stable(pdata));

    // R3: the strobe only falls after a phase-2 pulse
    assert_strobe_fall_R3: assert property (@(posedge clk) disable iff (pwr_clr)
        $fell(strobe_n) |-> $past(ph2_edge));

    // R4, R5: the strobe only rises at mid-sync or on a fresh write
    assert_strobe_rise_R4: assert property (@(posedge clk) disable iff (pwr_clr)
        $rose(strobe_n) |-> (($past(ph2_edge) && $past(cyc_sync)) || $past(wr_sel)));

    // R7: the flag sets only from a low sample taken on a phase-2 pulse
    assert_ack_set_R7: assert property (@(posedge clk) disable iff (pwr_clr)
        $rose(ack) |-> ($past(ph2_edge, 2) && !$past(rdy_n, 2) && !$past(rd_sel)));

    // R10: a data read leaves the flag empty
    assert_read_clear_R10: assert property (@(posedge clk) disable iff (pwr_clr)
        rd_sel |=> !ack);

    // R9: the status bit shows the inverse of the acknowledge
    assert_status_sense_R9: assert property (@(posedge clk) disable iff (pwr_clr)
        stat_sel |-> (aux_val[STAT_POS] == !ack));

endmodule

bind pp_handshake pp_handshake_chk #(.DW(DW), .STAT_POS(STAT_POS)) u_chk (
    .clk      (clk),
    .pwr_clr  (pwr_clr),
    .ph2_edge (ph2_edge),
    .cyc_sync (cyc_sync),
    .wr_sel   (wr_sel),
    .rdy_n    (rdy_n),
    .rd_sel   (rd_sel),
    .stat_sel (stat_sel),
    .pdata    (pdata),
    .strobe_n (strobe_n),
    .ack      (ack),
    .aux_val  (aux_val)
);

// File: tb/sim_pp_handshake.sv
`timescale 1ns/1ps
module sim_pp_handshake;

    logic       clk = 1'b0;
    logic       pwr_clr = 1'b1;
    logic       ph2_edge = 1'b0, cyc_sync = 1'b0, wr_sel = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic       out_dis = 1'b0, rdy_n = 1'b1, rd_sel = 1'b0, stat_sel = 1'b0;
    logic [7:0] pdata, aux_en, aux_val;
    logic       pdata_en, strobe_n, ack;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state built from the requirements
    logic [7:0] m_dq;
    int         m_ost;   // 0 idle, 1 armed, 2 strobe
    logic       m_wq, m_s1, m_s1d, m_full;

    always #2 clk = ~clk;

    pp_handshake u0 (
        .clk(clk), .pwr_clr(pwr_clr), .ph2_edge(ph2_edge), .cyc_sync(cyc_sync),
        .wr_sel(wr_sel), .bus_din(bus_din), .out_dis(out_dis), .pdata(pdata),
        .pdata_en(pdata_en), .strobe_n(strobe_n), .rdy_n(rdy_n), .rd_sel(rd_sel),
        .ack(ack), .stat_sel(stat_sel), .aux_en(aux_en), .aux_val(aux_val)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_aux_en(input logic sel);
        return sel ? 8'h02 : 8'h00;
    endfunction

    function automatic logic [7:0] exp_aux_val(input logic sel, input logic full);
        return (sel && !full) ? 8'h02 : 8'h00;
    endfunction

    task automatic model_clear();
        m_dq = 8'h00; m_ost = 0; m_wq = 0; m_s1 = 0; m_s1d = 0; m_full = 0;
    endtask

    task automatic model_edge();
        logic lead, rise;
        lead = wr_sel && !m_wq;
        rise = m_s1 && !m_s1d;
        if (lead) begin
            m_dq  = bus_din;
            m_ost = 1;
        end else if (m_ost == 1 && ph2_edge) begin
            m_ost = 2;
        end else if (m_ost == 2 && ph2_edge && cyc_sync) begin
            m_ost = 0;
        end
        m_wq = wr_sel;
        if (rd_sel) m_full = 0;
        else if (rise) m_full = 1;
        m_s1d = m_s1;
        if (ph2_edge) m_s1 = !rdy_n;
    endtask

    task automatic check_all();
        chk("R2 pdata", pdata, m_dq);
        chk("R3 strobe_n", {7'd0, strobe_n}, {7'd0, (m_ost != 2)});
        chk("R6 pdata_en", {7'd0, pdata_en}, {7'd0, !out_dis});
        chk("R8 ack", {7'd0, ack}, {7'd0, m_full});
        chk("R9 aux_en", aux_en, exp_aux_en(stat_sel));
        chk("R9 aux_val", aux_val, exp_aux_val(stat_sel, m_full));
    endtask

    // one clock: inputs already driven at the negedge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd7421));
        model_clear();
        repeat (3) @(negedge clk);
        chk("R1 strobe_n in clear", {7'd0, strobe_n}, 8'h01);
        chk("R1 ack in clear", {7'd0, ack}, 8'h00);
        pwr_clr = 1'b0;
        step();
        chk("R1 pdata after clear", pdata, 8'h00);
        chk("R1 aux_en after clear", aux_en, 8'h00);

        // R2/R3: capture, hold, then strobe after next phase-2 pulse
        bus_din = 8'hA5; wr_sel = 1; ph2_edge = 1; step();
        chk("R3 no strobe in capture cycle", {7'd0, strobe_n}, 8'h01);
        bus_din = 8'h3C; ph2_edge = 0; step();
        chk("R2 held select no recapture", pdata, 8'hA5);
        chk("R3 armed waits", {7'd0, strobe_n}, 8'h01);
        ph2_edge = 1; step();
        chk("R3 strobe low", {7'd0, strobe_n}, 8'h00);
        // R4: release only at mid-sync
        ph2_edge = 0; cyc_sync = 1; step();
        chk("R4 sync alone keeps strobe", {7'd0, strobe_n}, 8'h00);
        ph2_edge = 1; cyc_sync = 0; step();
        chk("R4 ph2 alone keeps strobe", {7'd0, strobe_n}, 8'h00);
        cyc_sync = 1; step();
        chk("R4 released", {7'd0, strobe_n}, 8'h01);
        ph2_edge = 0; cyc_sync = 0; wr_sel = 0; step();

        // R5: new write during strobe
        wr_sel = 1; bus_din = 8'h5A; step();
        wr_sel = 0; ph2_edge = 1; step();
        ph2_edge = 0; step();
        chk("R5 strobe low before rewrite", {7'd0, strobe_n}, 8'h00);
        wr_sel = 1; bus_din = 8'hC3; step();
        chk("R5 rewrite releases", {7'd0, strobe_n}, 8'h01);
        chk("R5 rewrite captures", pdata, 8'hC3);
        wr_sel = 0; ph2_edge = 1; step();
        chk("R5 rearmed strobe", {7'd0, strobe_n}, 8'h00);
        cyc_sync = 1; step();
        ph2_edge = 0; cyc_sync = 0;

        // R6
        out_dis = 1; #1;
        chk("R6 disable", {7'd0, pdata_en}, 8'h00);
        step();
        out_dis = 0; #1;
        chk("R6 enable", {7'd0, pdata_en}, 8'h01);
        @(negedge clk);

        // R7: sample only on phase-2
        rdy_n = 0; step(); step();
        chk("R7 no sample without ph2", {7'd0, ack}, 8'h00);
        ph2_edge = 1; step();
        chk("R7 one clock after sample", {7'd0, ack}, 8'h00);
        ph2_edge = 0; step();
        chk("R7 ack set", {7'd0, ack}, 8'h01);
        stat_sel = 1; #1;
        chk("R9 full reads 0", aux_val, 8'h00);
        chk("R9 lane enable", aux_en, 8'h02);
        @(negedge clk);

        // R10/R11: read clears, held level does not retrigger
        rd_sel = 1; step();
        chk("R10 read clears", {7'd0, ack}, 8'h00);
        rd_sel = 0; ph2_edge = 1; step(); step(); step();
        chk("R11 held low no retrigger", {7'd0, ack}, 8'h00);
        chk("R9 empty reads 1", aux_val, 8'h02);
        rdy_n = 1; step();
        rdy_n = 0; step();
        ph2_edge = 0; step();
        chk("R11 fresh edge sets", {7'd0, ack}, 8'h01);

        // R10 priority over a same-cycle set
        rdy_n = 1; ph2_edge = 1; step();
        rd_sel = 1; ph2_edge = 0; step();
        rdy_n = 0; ph2_edge = 1; rd_sel = 0; step();
        rd_sel = 1; ph2_edge = 0; step();
        chk("R10 read beats set", {7'd0, ack}, 8'h00);
        rd_sel = 0; step();
        chk("R10 set not kept", {7'd0, ack}, 8'h00);
        stat_sel = 0;

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            ph2_edge = ($urandom_range(0, 3) == 0);
            cyc_sync = ($urandom_range(0, 2) == 0);
            wr_sel   = ($urandom_range(0, 9) == 0) ? !wr_sel : wr_sel;
            bus_din  = 8'($urandom);
            out_dis  = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 5) == 0) rdy_n = !rdy_n;
            rd_sel   = ($urandom_range(0, 11) == 0);
            stat_sel = ($urandom_range(0, 1) == 0);
            step();
        end

        // R1: clear in mid-run
        pwr_clr = 1; #1;
        model_clear();
        chk("R1 mid-run clear strobe", {7'd0, strobe_n}, 8'h01);
        chk("R1 mid-run clear ack", {7'd0, ack}, 8'h00);
        chk("R1 mid-run clear pdata", pdata, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule